// File: doc/BRIEF.md
# Banked 32 KiB-Window Cartridge Address Decoder

This block sits on the cartridge side of a console bus with a 24-bit address: an 8-bit bank and a 16-bit offset. It decides, with no clock, whether the current access goes to the cartridge ROM, to the battery-backed SRAM, or to neither. For the selected device it also forms the device address. Each bank holds 32 KiB of ROM. The linear ROM address is the low seven bank bits followed by the low fifteen offset bits, wrapped to the fitted ROM size.

Two decode styles are available through a static strap. The simple gate style ignores offset bit 15. The dedicated decoder style uses offset bit 15 to split every bank into a lower and an upper half. The SRAM window moves between the two styles. The top bank bit is never decoded, so the upper 128 banks mirror the lower 128. The console's own work RAM and I/O decode, the bus timing and the storage arrays all lie outside the block.

Top module: `lorom_cart_decoder`

## Requirements
- R1: Bank bit 7 is ignored. For every bank other than 7E, 7F, FE and FF, bank b and bank b XOR 80 produce identical enables and addresses at any offset.
- R2: Banks 7E and 7F never assert romCe or sramCe, whatever the offset, strobes or configuration.
- R3: In gate style (styleSel = 0), offset bit 15 has no effect on ROM decoding. A ROM bank is enabled at every offset, and offsets x and x+8000h give the same romAddr.
- R4: In gate style with SRAM fitted, every offset of banks 70 to 7D and F0 to FF selects SRAM and never ROM.
- R5: In dedicated style (styleSel = 1), ROM is selected only when offset bit 15 is 1. SRAM (when fitted) is selected only at offsets 0000 to 7FFF of banks 70 to 7D and F0 to FF. The upper halves of those banks select ROM.
- R6: With sramSizeSel = 0 (no SRAM), sramCe never asserts, and banks 70 to 7D and F0 to FF decode to ROM exactly like any other ROM bank.
- R7: sramSizeSel encodes the SRAM as follows: 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB. sramAddr is the offset reduced modulo the fitted size, so the contents repeat through the window.
- R8: romAddr equals {bank[6:0], offset[14:0]} modulo 32 KiB × 2^romSizeSel. The value romSizeSel = 7 means 128 banks (4 MiB).
- R9: romCe asserts only on a read with no write (rdStrobe = 1, wrStrobe = 0). sramCe asserts on a read or a write inside the SRAM window. With both strobes low, no enable asserts.
- R10: romCe and sramCe are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bankIn | input | 8 | Bank part of the bus address (A23 to A16) |
| offsetIn | input | 16 | Offset within the bank (A15 to A0) |
| rdStrobe | input | 1 | Read access in progress |
| wrStrobe | input | 1 | Write access in progress |
| styleSel | input | 1 | 0 selects gate style, 1 selects dedicated decoder style |
| sramSizeSel | input | 2 | Fitted SRAM: 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB |
| romSizeSel | input | 3 | log2 of the number of fitted 32 KiB ROM banks |
| romCe | output | 1 | ROM chip enable |
| romAddr | output | 22 | Linear ROM byte address |
| sramCe | output | 1 | SRAM chip enable |
| sramAddr | output | 15 | SRAM byte address |

## Verification
The bench probes the edges of each region.

- Offsets 7FFF and 8000 in every bank expose a style that uses offset bit 15 where it should not, or ignores it where it should not. Such a design would enable ROM in lower halves under the dedicated decoder, or drop SRAM from upper halves under the gate style.
- Banks 7D/7E and FD/FE/FF catch a design that stretches the SRAM range into the console's banks, or that treats FE and FF like 7E and 7F. The result would be contention with work RAM, or SRAM missing from the top banks.
- The smallest ROM and SRAM sizes show whether the wrap mask is applied. Without it, addresses leak beyond the fitted part.
- Write cycles show whether ROM is driven during a write.

// File: rtl/cart_pkg.sv
package cart_pkg;

  typedef enum logic {
    DEC_GATES     = 1'b0,
    DEC_DEDICATED = 1'b1
  } decStyle_t;

  typedef enum logic [1:0] {
    SRAM_NONE = 2'd0,
    SRAM_2K   = 2'd1,
    SRAM_8K   = 2'd2,
    SRAM_32K  = 2'd3
  } sramSize_t;

  // Strobes from the region decode to the address datapath.
  typedef struct packed {
    logic romSel;
    logic sramSel;
  } selStrobe_t;

endpackage

// File: rtl/cart_region_ctl.sv
module cart_region_ctl
  import cart_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [BANK_W-1:0] bank,
  input  logic              offHi,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  decStyle_t         style,
  input  sramSize_t         sramSize,
  output selStrobe_t        sel
);

  localparam int LOW_W = BANK_W - 1;

  logic [LOW_W-1:0] lowBank;
  logic sysBank;
  logic sramBank;
  logic sramFitted;
  logic sramRegion;
  logic romRegion;

  always_comb begin
    // The top bank bit is never looked at, except to spare FE/FF.
    lowBank    = bank[LOW_W-1:0];
    sysBank    = !bank[BANK_W-1] && (lowBank[LOW_W-1:1] == {(LOW_W-1){1'b1}});
    sramBank   = (lowBank[LOW_W-1:LOW_W-3] == 3'b111) && !sysBank;
    sramFitted = (sramSize != SRAM_NONE);
    sramRegion = sramFitted && sramBank && ((style == DEC_GATES) || !offHi);
    romRegion  = !sysBank && !sramRegion && ((style == DEC_GATES) || offHi);

    sel.sramSel = sramRegion && (rdStrobe || wrStrobe);
    sel.romSel  = romRegion && rdStrobe && !wrStrobe;
  end

endmodule

// File: rtl/cart_addr_dp.sv
module cart_addr_dp
  import cart_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int OFFS_W     = 15,
  parameter int ROMSZ_W    = 3
) (
  input  selStrobe_t              sel,
  input  logic [ROM_BANK_W-1:0]   bankLow,
  input  logic [OFFS_W-1:0]       offLow,
  input  logic [ROMSZ_W-1:0]      romSizeSel,
  input  sramSize_t               sramSize,
  output logic                    romCe,
  output logic [ROM_BANK_W+OFFS_W-1:0] romAddr,
  output logic                    sramCe,
  output logic [OFFS_W-1:0]       sramAddr
);

  localparam int ROM_AW    = ROM_BANK_W + OFFS_W;
  localparam int SRAM_2K_W = 11;
  localparam int SRAM_8K_W = 13;

  logic [ROM_AW:0]   romLimit;
  logic [ROM_AW-1:0] romMask;
  logic [OFFS_W-1:0] sramMask;

  always_comb begin
    romLimit = (ROM_AW+1)'(1) << (OFFS_W + int'(romSizeSel));
    romMask  = ROM_AW'(romLimit - (ROM_AW+1)'(1));
    romAddr  = {bankLow, offLow} & romMask;

    unique case (sramSize)
      SRAM_2K:  sramMask = OFFS_W'((1 << SRAM_2K_W) - 1);
      SRAM_8K:  sramMask = OFFS_W'((1 << SRAM_8K_W) - 1);
      default:  sramMask = {OFFS_W{1'b1}};
    endcase
    sramAddr = offLow & sramMask;

    romCe  = sel.romSel;
    sramCe = sel.sramSel;
  end

endmodule

// File: rtl/lorom_cart_decoder.sv
module lorom_cart_decoder
  import cart_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int OFFS_W  = 16,
  parameter int ROMSZ_W = 3,
  localparam int ROM_AW = (BANK_W - 1) + (OFFS_W - 1)
) (
  input  logic [BANK_W-1:0]  bankIn,
  input  logic [OFFS_W-1:0]  offsetIn,
  input  logic               rdStrobe,
  input  logic               wrStrobe,
  input  logic               styleSel,
  input  logic [1:0]         sramSizeSel,
  input  logic [ROMSZ_W-1:0] romSizeSel,
  output logic               romCe,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               sramCe,
  output logic [OFFS_W-2:0]  sramAddr
);

  selStrobe_t sel;
  decStyle_t  style;
  sramSize_t  sramSize;

  assign style    = decStyle_t'(styleSel);
  assign sramSize = sramSize_t'(sramSizeSel);

  cart_region_ctl #(.BANK_W(BANK_W)) i_ctl (
    .bank     (bankIn),
    .offHi    (offsetIn[OFFS_W-1]),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .style    (style),
    .sramSize (sramSize),
    .sel      (sel)
  );

  cart_addr_dp #(
    .ROM_BANK_W (BANK_W - 1),
    .OFFS_W     (OFFS_W - 1),
    .ROMSZ_W    (ROMSZ_W)
  ) i_dp (
    .sel        (sel),
    .bankLow    (bankIn[BANK_W-2:0]),
    .offLow     (offsetIn[OFFS_W-2:0]),
    .romSizeSel (romSizeSel),
    .sramSize   (sramSize),
    .romCe      (romCe),
    .romAddr    (romAddr),
    .sramCe     (sramCe),
    .sramAddr   (sramAddr)
  );

endmodule

// File: rtl/lorom_cart_decoder_chk.sv
module lorom_cart_decoder_chk #(
  parameter int BANK_W = 8
) (
  input logic [BANK_W-1:0] bankIn,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic [1:0]        sramSizeSel,
  input logic              romCe,
  input logic              sramCe
);

  always_comb begin
    AST_ONE_ENABLE: assert (!(romCe && sramCe)); // R10
    AST_NO_ROM_ON_WRITE: assert (!(wrStrobe && romCe)); // R9
    AST_IDLE_QUIET: assert (rdStrobe || wrStrobe || (!romCe && !sramCe)); // R9
    AST_SYS_BANKS_QUIET: assert (!((bankIn == 8'h7E || bankIn == 8'h7F) && (romCe || sramCe))); // R2
    AST_ABSENT_SRAM: assert (!(sramSizeSel == 2'd0 && sramCe)); // R6
    AST_SRAM_BANKS: assert (!sramCe || (bankIn[6:4] == 3'b111)); // R4
  end

endmodule

bind lorom_cart_decoder lorom_cart_decoder_chk #(.BANK_W(BANK_W)) i_chk (
  .bankIn      (bankIn),
  .wrStrobe    (wrStrobe),
  .rdStrobe    (rdStrobe),
  .sramSizeSel (sramSizeSel),
  .romCe       (romCe),
  .sramCe      (sramCe)
);

// File: tb/test_lorom_cart_decoder.sv
module test_lorom_cart_decoder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  bankIn;
  logic [15:0] offsetIn;
  logic        rdStrobe, wrStrobe, styleSel;
  logic [1:0]  sramSizeSel;
  logic [2:0]  romSizeSel;
  logic        romCe, sramCe;
  logic [21:0] romAddr;
  logic [14:0] sramAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  lorom_cart_decoder i_lorom_cart_decoder (
    .bankIn(bankIn), .offsetIn(offsetIn), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .styleSel(styleSel), .sramSizeSel(sramSizeSel), .romSizeSel(romSizeSel),
    .romCe(romCe), .romAddr(romAddr), .sramCe(sramCe), .sramAddr(sramAddr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [2:0]  rs;
    logic [7:0]  bk;
    logic [15:0] of;
    logic        rd;
    logic        wr;
    logic        eRom;
    logic        eSram;
    logic [21:0] eRomA;
    logic [14:0] eSramA;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 3'd7, 8'h00, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 22'h0,      15'h0,    4'd9},  // R9 idle
    '{1'b0, 2'd0, 3'd7, 8'h00, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, 22'h000000, 15'h0,    4'd8},  // R8
    '{1'b0, 2'd0, 3'd7, 8'h40, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 22'h201234, 15'h0,    4'd3},  // R3
    '{1'b0, 2'd0, 3'd7, 8'hC0, 16'h9234, 1'b1, 1'b0, 1'b1, 1'b0, 22'h201234, 15'h0,    4'd1},  // R1
    '{1'b0, 2'd3, 3'd7, 8'h7E, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 22'h0,      15'h0,    4'd2},  // R2
    '{1'b0, 2'd3, 3'd7, 8'h70, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0,      15'h7FFF, 4'd4},  // R4
    '{1'b0, 2'd1, 3'd7, 8'hF5, 16'h1800, 1'b0, 1'b1, 1'b0, 1'b1, 22'h0,      15'h0000, 4'd7},  // R7
    '{1'b1, 2'd2, 3'd7, 8'h70, 16'h9ABC, 1'b1, 1'b0, 1'b1, 1'b0, 22'h381ABC, 15'h0,    4'd5},  // R5
    '{1'b1, 2'd2, 3'd7, 8'h71, 16'h2ABC, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0,      15'h0ABC, 4'd5},  // R5
    '{1'b1, 2'd2, 3'd7, 8'h20, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 22'h0,      15'h0,    4'd5},  // R5
    '{1'b0, 2'd0, 3'd7, 8'h72, 16'h0005, 1'b1, 1'b0, 1'b1, 1'b0, 22'h390005, 15'h0,    4'd6},  // R6
    '{1'b0, 2'd0, 3'd3, 8'h2B, 16'h8010, 1'b1, 1'b0, 1'b1, 1'b0, 22'h018010, 15'h0,    4'd8},  // R8
    '{1'b0, 2'd0, 3'd7, 8'h10, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 22'h0,      15'h0,    4'd9},  // R9
    '{1'b1, 2'd3, 3'd7, 8'hFF, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 22'h0,      15'h0000, 4'd5}   // R5
  };

  task automatic drive(input logic st, input logic [1:0] sz, input logic [2:0] rs,
                       input logic [7:0] bk, input logic [15:0] of,
                       input logic rd, input logic wr);
    @(posedge clk);
    styleSel = st; sramSizeSel = sz; romSizeSel = rs;
    bankIn = bk; offsetIn = of; rdStrobe = rd; wrStrobe = wr;
    @(negedge clk);
  endtask

  task automatic compare(input logic eRom, input logic eSram, input logic [21:0] eRomA,
                         input logic [14:0] eSramA, input int req);
    checks = checks + 1;
    if (romCe !== eRom || sramCe !== eSram ||
        (eRom && romAddr !== eRomA) || (eSram && sramAddr !== eSramA) ||
        (romCe && sramCe)) begin
      errors = errors + 1;
      $display("FAIL R%0d bank=%h off=%h st=%0d sz=%0d rs=%0d: got rom=%0d/%h sram=%0d/%h, expected rom=%0d/%h sram=%0d/%h",
               req, bankIn, offsetIn, styleSel, sramSizeSel, romSizeSel,
               romCe, romAddr, sramCe, sramAddr, eRom, eRomA, eSram, eSramA);
    end
  endtask

  // Reference decode written from the requirements.
  task automatic reference(input logic st, input logic [1:0] sz, input logic [2:0] rs,
                           input logic [7:0] bk, input logic [15:0] of,
                           input logic rd, input logic wr,
                           output logic eRom, output logic eSram,
                           output logic [21:0] eRomA, output logic [14:0] eSramA,
                           output int req);
    int lowB;
    int sramBytes;
    bit sys, inSram, fitted;
    lowB   = int'(bk) % 128;
    sys    = (bk == 8'h7E) || (bk == 8'h7F);
    inSram = (bk >= 8'h70 && bk <= 8'h7D) || (bk >= 8'hF0);
    fitted = (sz != 2'd0);
    eRom = 1'b0; eSram = 1'b0;
    eRomA  = 22'((lowB * 32768 + int'(of) % 32768) % (32768 << rs));
    sramBytes = (sz == 2'd1) ? 2048 : (sz == 2'd2) ? 8192 : 32768;
    eSramA = 15'(int'(of) % sramBytes);
    if (sys) begin
      req = 2;                                          // R2
    end else if (fitted && inSram && (st == 1'b0 || of < 16'h8000)) begin
      eSram = rd || wr;
      req = (st == 1'b0) ? 4 : 5;                        // R4 R5
    end else if (st == 1'b0 || of >= 16'h8000) begin
      eRom = rd && !wr;
      req = (!fitted && inSram) ? 6 : ((st == 1'b0) ? 3 : 8); // R6 R3 R8
    end else begin
      req = 5;
    end
    if (!rd && !wr) req = 9;                             // R9
  endtask

  initial begin
    logic eRom, eSram;
    logic [21:0] eRomA;
    logic [14:0] eSramA;
    int req;
    logic [15:0] offs [4];
    logic [2:0]  sizes [3];
    offs[0] = 16'h0000; offs[1] = 16'h7FFF; offs[2] = 16'h8000; offs[3] = 16'hFFFF;
    sizes[0] = 3'd0; sizes[1] = 3'd5; sizes[2] = 3'd7;

    styleSel = 0; sramSizeSel = 0; romSizeSel = 0; bankIn = 0; offsetIn = 0;
    rdStrobe = 0; wrStrobe = 0;

    // Idle state: nothing enabled with no strobe (R9)
    drive(1'b0, 2'd3, 3'd7, 8'h70, 16'h0000, 1'b0, 1'b0);
    compare(1'b0, 1'b0, 22'h0, 15'h0, 9);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].st, VECS[i].sz, VECS[i].rs, VECS[i].bk, VECS[i].of, VECS[i].rd, VECS[i].wr);
      compare(VECS[i].eRom, VECS[i].eSram, VECS[i].eRomA, VECS[i].eSramA, int'(VECS[i].req));
    end

    // Full sweep against the reference (R1 mirror banks covered, R10 exclusivity)
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int ri = 0; ri < 3; ri++)
          for (int bk = 0; bk < 256; bk++)
            for (int oi = 0; oi < 4; oi++)
              for (int acc = 0; acc < 2; acc++) begin
                reference(1'(st), 2'(sz), sizes[ri], 8'(bk), offs[oi],
                          acc == 0, acc == 1, eRom, eSram, eRomA, eSramA, req);
                drive(1'(st), 2'(sz), sizes[ri], 8'(bk), offs[oi], acc == 0, acc == 1);
                if (bk >= 128 && bk < 240) req = 1;      // R1
                compare(eRom, eSram, eRomA, eSramA, req);
              end

    // Corner: small SRAM mirrors through dedicated window (R7)
    drive(1'b1, 2'd1, 3'd7, 8'h7D, 16'h7FFF, 1'b1, 1'b0);
    compare(1'b0, 1'b1, 22'h0, 15'h07FF, 7);
    // Corner: R10 dedicated upper half of SRAM bank with write -> nothing
    drive(1'b1, 2'd3, 3'd7, 8'h7C, 16'h8000, 1'b0, 1'b1);
    compare(1'b0, 1'b0, 22'h0, 15'h0, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule